// File: doc/BRIEF.md
# Program Memory Fetch Selector

This block sits between an 8-bit processor core's fetch path and its two sources of program memory: an on-chip ROM and an external program bus. For every program memory read it decides which of the two is read, using a boundary address and a routing mode taken from an external-access input pin. The pin is captured while reset is held. Once reset is released the captured value is frozen and later changes on the pin have no effect.

Two kinds of read arrive: opcode or immediate-operand fetches, and table-lookup reads. When the security input is high, a table-lookup read is checked against the location of the instruction that issued it. That location is the issuing instruction's program counter, classified with the same internal/external rule. Code that runs from external memory may then read only external program memory. A table-lookup read that it aims at internal ROM is refused. The refused read starts no bus cycle, raises a one-cycle blocked flag, and returns 0x00 in place of ROM data.

The routing decision is registered. The select, strobe and blocked outputs appear in the cycle after the request. In that same cycle the read data is chosen from the synchronous ROM output or from the external bus data.

Top module: `pmem_route_sel`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle that follows it, `sel_int_o`, `ext_req_o` and `blocked_o` are all 0.
- R2: The routing mode is the value of `ext_pin_i` at the last clock edge with `rst` high. Changes on `ext_pin_i` after reset do not change routing.
- R3: With the captured mode at 1, a valid request to an address from 0x0000 to 0xBFFF gives `sel_int_o`=1 and `ext_req_o`=0 in the next cycle, unless R7 blocks the request.
- R4: With the captured mode at 1, a valid request to an address from 0xC000 to 0xFFFF gives `ext_req_o`=1 and `sel_int_o`=0 in the next cycle.
- R5: With the captured mode at 0, every valid request gives `ext_req_o`=1 and `sel_int_o`=0 in the next cycle, for any address.
- R6: With `secure_en_i`=1, a table-lookup read (`req_kind_i`=1) whose `instr_pc_i` is classified internal reaches both internal and external targets without being blocked.
- R7: With `secure_en_i`=1, a table-lookup read whose `instr_pc_i` is classified external and whose target is internal gives, in the next cycle, `blocked_o`=1, `sel_int_o`=0, `ext_req_o`=0 and `rdata_o`=0x00. At most one of the three flags is ever high.
- R8: With `secure_en_i`=0, no request is ever blocked.
- R9: Opcode fetches (`req_kind_i`=0) are never blocked, whatever `instr_pc_i` is.
- R10: In the cycle after a request, `rdata_o` equals `rom_data_i` when `sel_int_o`=1 and equals `ext_data_i` when `ext_req_o`=1.
- R11: A cycle with `req_valid_i`=0 gives all three flags at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the window in which the mode pin is captured |
| ext_pin_i | input | 1 | External-access mode pin (1: split routing, 0: all external) |
| secure_en_i | input | 1 | Read-protection enable for table-lookup reads |
| req_valid_i | input | 1 | A program memory read is requested this cycle |
| req_kind_i | input | 1 | 0: opcode/immediate fetch, 1: table-lookup read |
| req_addr_i | input | 16 | Target program address |
| instr_pc_i | input | 16 | Program counter of the instruction issuing the read |
| rom_data_i | input | 8 | Synchronous on-chip ROM read data (valid the cycle after the address) |
| ext_data_i | input | 8 | External program bus read data |
| sel_int_o | output | 1 | Registered: the request is served from on-chip ROM |
| ext_req_o | output | 1 | Registered: external program bus read strobe |
| blocked_o | output | 1 | Registered: one-cycle flag for a refused table-lookup read |
| rdata_o | output | 8 | Read data returned to the core |

## Verification
On every cycle the assertions check the following: the three flags are never high together, and a blocked read always returns zero. An idle cycle leaves all flags low, and a valid request raises exactly one flag. The captured mode never moves after reset, and the all-external mode never selects ROM. Neither opcode fetches, nor reads issued from internal code, nor reads made with protection off are ever refused. Only the bench's scenarios show the following: that the 0xBFFF/0xC000 boundary sits exactly where it should for both the target and the issuing PC, and that a pin toggled after reset is really ignored. They also show that the returned bytes come from the correct source.

// File: rtl/pmem_sel_pkg.sv
package pmem_sel_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic {
    KIND_CODE  = 1'b0,
    KIND_TABLE = 1'b1
  } req_kind_e;

  typedef struct packed {
    logic to_int;
    logic to_ext;
    logic deny;
  } route_t;

  // An address lies in on-chip ROM only in split mode and at or below the last ROM location.
  function automatic logic in_rom(input logic [ADDR_W-1:0] addr,
                                  input logic [ADDR_W-1:0] rom_last,
                                  input logic              split_mode);
    return split_mode && (addr <= rom_last);
  endfunction

  // Protection refuses a table read that comes from external code and aims at ROM.
  function automatic logic refuse(input logic secure, input logic is_table,
                                  input logic pc_int, input logic tgt_int);
    return secure && is_table && !pc_int && tgt_int;
  endfunction
endpackage

// File: rtl/pmem_mode_latch.sv
module pmem_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic mode_o
);
  // Tracks the pin only while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (rst) mode_o <= pin_i;
  end
endmodule

// File: rtl/pmem_route_decide.sv
module pmem_route_decide
  import pmem_sel_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_LAST = 16'hBFFF
) (
  input  logic              mode_i,
  input  logic              secure_i,
  input  logic              valid_i,
  input  logic              kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              tgt_int_o,
  output logic              pc_int_o,
  output route_t            route_o
);
  logic deny_w;

  assign tgt_int_o = in_rom(addr_i, ROM_LAST, mode_i);
  assign pc_int_o  = in_rom(pc_i, ROM_LAST, mode_i);
  assign deny_w    = refuse(secure_i, kind_i == KIND_TABLE, pc_int_o, tgt_int_o);

  always_comb begin
    route_o.deny   = valid_i && deny_w;
    route_o.to_int = valid_i && tgt_int_o && !deny_w;
    route_o.to_ext = valid_i && !tgt_int_o;
  end
endmodule

// File: rtl/pmem_rdata_mux.sv
module pmem_rdata_mux #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] BLOCK_VAL = '0
) (
  input  logic              sel_int_i,
  input  logic              blocked_i,
  input  logic [DATA_W-1:0] rom_i,
  input  logic [DATA_W-1:0] ext_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    if (blocked_i)      data_o = BLOCK_VAL;
    else if (sel_int_i) data_o = rom_i;
    else                data_o = ext_i;
  end
endmodule

// File: rtl/pmem_route_sel.sv
module pmem_route_sel
  import pmem_sel_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] ROM_LAST  = 16'hBFFF,
  parameter logic [DATA_W-1:0] BLOCK_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_pin_i,
  input  logic              secure_en_i,
  input  logic              req_valid_i,
  input  logic              req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [ADDR_W-1:0] instr_pc_i,
  input  logic [DATA_W-1:0] rom_data_i,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic              sel_int_o,
  output logic              ext_req_o,
  output logic              blocked_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic   ea_lat_w;
  logic   tgt_int_w;
  logic   pc_int_w;
  route_t route_w;
  route_t route_q;

  pmem_mode_latch u_mode (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (ext_pin_i),
    .mode_o (ea_lat_w)
  );

  pmem_route_decide #(.ROM_LAST(ROM_LAST)) u_decide (
    .mode_i    (ea_lat_w),
    .secure_i  (secure_en_i),
    .valid_i   (req_valid_i),
    .kind_i    (req_kind_i),
    .addr_i    (req_addr_i),
    .pc_i      (instr_pc_i),
    .tgt_int_o (tgt_int_w),
    .pc_int_o  (pc_int_w),
    .route_o   (route_w)
  );

  always_ff @(posedge clk) begin
    if (rst) route_q <= '0;
    else     route_q <= route_w;
  end

  assign sel_int_o = route_q.to_int;
  assign ext_req_o = route_q.to_ext;
  assign blocked_o = route_q.deny;

  pmem_rdata_mux #(.DATA_W(DATA_W), .BLOCK_VAL(BLOCK_VAL)) u_mux (
    .sel_int_i (route_q.to_int),
    .blocked_i (route_q.deny),
    .rom_i     (rom_data_i),
    .ext_i     (ext_data_i),
    .data_o    (rdata_o)
  );
endmodule

// File: rtl/pmem_route_chk.sv
module pmem_route_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              secure_en_i,
  input logic              req_valid_i,
  input logic              req_kind_i,
  input logic              sel_int_o,
  input logic              ext_req_o,
  input logic              blocked_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ea_lat_w,
  input logic              pc_int_w
);
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_int_o, ext_req_o, blocked_o}));

  assert_blocked_zero_data_R7: assert property (@(posedge clk) disable iff (rst)
    blocked_o |-> rdata_o == '0);

  assert_idle_no_flags_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(req_valid_i)) |-> !(sel_int_o || ext_req_o || blocked_o));

  assert_one_flag_per_req_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid_i)) |-> $countones({sel_int_o, ext_req_o, blocked_o}) == 1);

  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(ea_lat_w));

  assert_all_external_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !ea_lat_w) |-> !sel_int_o && !blocked_o);

  assert_unsecured_open_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(secure_en_i)) |-> !blocked_o);

  assert_fetch_open_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(req_kind_i)) |-> !blocked_o);

  assert_internal_caller_open_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pc_int_w)) |-> !blocked_o);
endmodule

bind pmem_route_sel pmem_route_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .secure_en_i (secure_en_i),
  .req_valid_i (req_valid_i),
  .req_kind_i  (req_kind_i),
  .sel_int_o   (sel_int_o),
  .ext_req_o   (ext_req_o),
  .blocked_o   (blocked_o),
  .rdata_o     (rdata_o),
  .ea_lat_w    (ea_lat_w),
  .pc_int_w    (pc_int_w)
);

// File: tb/tb_pmem_route_sel.sv
module tb_pmem_route_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_pin_i = 1'b1;
  logic        secure_en_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_kind_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [15:0] instr_pc_i = '0;
  logic [7:0]  rom_q = '0;
  logic [7:0]  ext_q = '0;
  logic        sel_int_o, ext_req_o, blocked_o;
  logic [7:0]  rdata_o;
  logic [7:0]  rom_mem [0:255];
  int          n_chk = 0;
  int          n_fail = 0;
  logic        mode_ref = 1'b1;

  always #10 clk = ~clk;

  pmem_route_sel dut (
    .clk(clk), .rst(rst), .ext_pin_i(ext_pin_i), .secure_en_i(secure_en_i),
    .req_valid_i(req_valid_i), .req_kind_i(req_kind_i), .req_addr_i(req_addr_i),
    .instr_pc_i(instr_pc_i), .rom_data_i(rom_q), .ext_data_i(ext_q),
    .sel_int_o(sel_int_o), .ext_req_o(ext_req_o), .blocked_o(blocked_o), .rdata_o(rdata_o)
  );

  function automatic logic [7:0] ext_f(input logic [15:0] a);
    return (~a[7:0]) + a[15:8];
  endfunction

  // Synchronous ROM and external bus models: data arrives one cycle after the address.
  always @(posedge clk) begin
    rom_q <= rom_mem[req_addr_i[7:0]] ^ req_addr_i[15:8];
    ext_q <= ext_f(req_addr_i);
  end

  function automatic logic on_chip(input logic m, input logic [15:0] a);
    return m && !(a >= 16'hC000);
  endfunction

  task automatic check(input string tag, input logic m, input logic sec, input logic v,
                       input logic k, input logic [15:0] a, input logic [15:0] pc);
    logic t, p, b, s, e;
    logic [7:0] d;
    t = on_chip(m, a);
    p = on_chip(m, pc);
    b = v && sec && k && t && !p;
    s = v && t && !b;
    e = v && !t;
    d = b ? 8'h00 : (s ? (rom_mem[a[7:0]] ^ a[15:8]) : ext_f(a));
    n_chk++;
    if ({sel_int_o, ext_req_o, blocked_o} !== {s, e, b} || rdata_o !== d) begin
      n_fail++;
      $display("FAIL %s addr=%h pc=%h actual sel/ext/blk=%b%b%b data=%h expected=%b%b%b data=%h",
               tag, a, pc, sel_int_o, ext_req_o, blocked_o, rdata_o, s, e, b, d);
    end
  endtask

  task automatic do_req(input string tag, input logic v, input logic k,
                        input logic [15:0] a, input logic [15:0] pc);
    req_valid_i = v; req_kind_i = k; req_addr_i = a; instr_pc_i = pc;
    @(posedge clk); @(negedge clk);
    check(tag, mode_ref, secure_en_i, v, k, a, pc);
    req_valid_i = 1'b0;
  endtask

  task automatic do_reset(input logic m);
    rst = 1'b1; ext_pin_i = m; req_valid_i = 1'b1; req_addr_i = 16'h0100;
    repeat (2) @(negedge clk);
    n_chk++;
    if ({sel_int_o, ext_req_o, blocked_o} !== 3'b000) begin
      n_fail++;
      $display("FAIL R1 reset flags actual=%b%b%b expected=000", sel_int_o, ext_req_o, blocked_o);
    end
    rst = 1'b0; mode_ref = m; ext_pin_i = ~m; req_valid_i = 1'b0;
    @(negedge clk);
    n_chk++;
    if ({sel_int_o, ext_req_o, blocked_o} !== 3'b000) begin
      n_fail++;
      $display("FAIL R1 post-reset flags actual=%b%b%b expected=000", sel_int_o, ext_req_o, blocked_o);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) rom_mem[i] = 8'(i * 37 + 11);
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset(1'b1);
    // Split mode boundaries (pin now driven low: R2)
    do_req("R3 bottom", 1, 0, 16'h0000, 16'h0000);
    do_req("R3 last ROM R2", 1, 0, 16'hBFFF, 16'h0000);
    do_req("R4 first ext", 1, 0, 16'hC000, 16'h0000);
    do_req("R4 top", 1, 0, 16'hFFFF, 16'h0000);
    do_req("R11 idle", 0, 0, 16'h1234, 16'h0000);
    do_req("R10 rom data", 1, 1, 16'h3A5C, 16'h0010);
    secure_en_i = 1'b1;
    do_req("R6 int caller int tgt", 1, 1, 16'h0040, 16'hBFFF);
    do_req("R6 int caller ext tgt", 1, 1, 16'hD000, 16'h0100);
    do_req("R7 ext caller int tgt", 1, 1, 16'hBFFF, 16'hC000);
    do_req("R7 ext caller ext tgt", 1, 1, 16'hC000, 16'hFFFF);
    do_req("R9 fetch ext caller", 1, 0, 16'h0200, 16'hC000);
    secure_en_i = 1'b0;
    do_req("R8 unsecured ext caller", 1, 1, 16'h0200, 16'hC000);
    do_reset(1'b0);
    secure_en_i = 1'b1;
    do_req("R5 low addr", 1, 0, 16'h0000, 16'h0000);
    do_req("R5 table R2", 1, 1, 16'h8000, 16'hE000);
    // Random phases
    for (int ph = 0; ph < 4; ph++) begin
      do_reset(1'($urandom));
      for (int j = 0; j < 60; j++) begin
        logic [15:0] a, pc;
        secure_en_i = 1'($urandom);
        ext_pin_i = 1'($urandom);
        a  = ($urandom % 4 == 0) ? (16'hBFFE + 16'($urandom % 3)) : 16'($urandom);
        pc = ($urandom % 4 == 0) ? (16'hBFFE + 16'($urandom % 3)) : 16'($urandom);
        do_req("R2/R3/R4/R5/R6/R7/R8/R9/R10/R11 random", 1'($urandom % 5 != 0),
               1'($urandom), a, pc);
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule